// File: doc/BRIEF.md
# Loop-Tick PID Duty Regulator with Undervoltage Trip

This block closes a voltage regulation loop in hardware. On each loop-tick strobe it takes an 8-bit target level, an 8-bit sample of the regulated output and an 8-bit sample of the raw supply. It forms the control error in 16-bit two's complement and adds three terms: proportional, difference and a running integral. From the total it derives an 8-bit PWM duty word. A done strobe marks the cycle in which the new duty is valid. The gains are elaboration-time parameters, and the duty holds its value between ticks.

A negative total is clamped so that the converter switch stays off, and an overload flag is raised while this holds. When a tick finds the raw supply below the trip level, a permanent shutdown latches. The duty is then held at zero and a trip flag is lit. From then on every tick is refused until reset.

Top module: `pid_trip_ctrl`

## Requirements
- R1: After reset, duty_o is 0x00 and done_o, ovld_o and trip_o are 0. The integral total and the stored previous error are both zero.
- R2: The error e0 is (setpt_i - vout_i) taken modulo 256. It is then sign-extended to 16 bits, with the upper byte 0xFF when bit 7 is 1 and 0x00 when bit 7 is 0.
- R3: The proportional term is KP * e0, kept to its low 16 bits.
- R4: The difference term is KD * (e1 - e0), kept to 16 bits. Here e1 is the error of the last completed iteration, and e0 replaces e1 at the end of each completed iteration.
- R5: Each completed iteration adds KI * e0 to a 16-bit wrapping integral total. The updated total is the one used in that same iteration's sum.
- R6: The sum is integral + proportional + difference, with 16-bit wraparound. When sum bit 15 is 1, the duty is 0x00 and ovld_o is 1. Otherwise ovld_o is 0.
- R7: When the sum is not negative, duty_o equals bits [10:3] of the sum.
- R8: done_o is a one-cycle pulse on the clock edge after an accepted tick. duty_o and ovld_o change only on that edge.
- R9: A tick with vin_i below 0xC1 sets trip_o and drives duty_o to 0x00 on the same edge. A tick with vin_i equal to 0xC1 does not trip.
- R10: Once trip_o is set, ticks produce no done_o pulse, duty_o stays 0x00 and trip_o stays 1 until reset.
- R11: The tick that trips still pulses done_o and still updates ovld_o from that iteration's sum. It does not update the integral or the previous error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Loop-tick strobe, starts one iteration |
| setpt_i | input | 8 | Target output level |
| vout_i | input | 8 | Regulated output sample |
| vin_i | input | 8 | Raw supply sample |
| duty_o | output | 8 | PWM duty word |
| done_o | output | 1 | Duty-valid pulse |
| ovld_o | output | 1 | Negative-sum clamp indicator |
| trip_o | output | 1 | Latched undervoltage shutdown |

## Verification
The overload clamp and the undervoltage trip can act on the same tick: one iteration can produce a negative sum while also seeing a low supply. The bench provokes this by issuing a tick with vout_i above setpt_i and vin_i at 0xC0, after the integral has been driven negative. It then expects duty_o at zero, done_o pulsed, and both ovld_o and trip_o set together. A following tick with a large positive error must leave all of them unchanged and produce no done_o.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int PID_W = 16;
  localparam int SMP_W = 8;

  typedef logic [PID_W-1:0] word_t;
  typedef logic [SMP_W-1:0] smp_t;

  // modulo-256 difference widened by sign extension
  function automatic word_t err_ext(input smp_t tgt, input smp_t meas);
    smp_t d;
    d = tgt - meas;
    return {{(PID_W-SMP_W){d[SMP_W-1]}}, d};
  endfunction

  // gain product truncated to the datapath width (two's complement wrap)
  function automatic word_t mulw(input word_t a, input word_t k);
    logic [2*PID_W-1:0] p;
    p = a * k;
    return p[PID_W-1:0];
  endfunction
endpackage

// File: rtl/pid_err_terms.sv
module pid_err_terms
  import pid_pkg::*;
#(
  parameter int KP = 4,
  parameter int KD = 2
) (
  input  smp_t  setpt,
  input  smp_t  vout,
  input  word_t e_prev,
  output word_t e_now,
  output word_t p_term,
  output word_t d_term
);
  localparam word_t KP_W = PID_W'(KP);
  localparam word_t KD_W = PID_W'(KD);

  assign e_now  = err_ext(setpt, vout);
  assign p_term = mulw(e_now, KP_W);

  generate
    if (KD == 0) begin : g_no_diff
      assign d_term = '0;
    end else begin : g_diff
      assign d_term = mulw(e_prev - e_now, KD_W);
    end
  endgenerate
endmodule

// File: rtl/pid_integ.sv
module pid_integ
  import pid_pkg::*;
#(
  parameter int KI = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  commit,
  input  word_t e_now,
  output word_t i_next
);
  localparam word_t KI_W = PID_W'(KI);
  word_t i_q;

  assign i_next = i_q + mulw(e_now, KI_W);

  always_ff @(posedge clk) begin
    if (!rst_n)      i_q <= '0;
    else if (commit) i_q <= i_next;
  end
endmodule

// File: rtl/pid_out_stage.sv
module pid_out_stage
  import pid_pkg::*;
#(
  parameter int DUTY_LSB = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go,
  input  logic  force_off,
  input  word_t i_term,
  input  word_t p_term,
  input  word_t d_term,
  output logic  sum_neg,
  output smp_t  duty_q,
  output logic  ovld_q,
  output logic  done_q
);
  localparam int DUTY_MSB = DUTY_LSB + SMP_W - 1;
  word_t sum;

  assign sum     = i_term + p_term + d_term;
  assign sum_neg = sum[PID_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_q <= '0;
      ovld_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= go;
      if (go) begin
        ovld_q <= sum_neg;
        duty_q <= (sum_neg || force_off) ? '0 : sum[DUTY_MSB:DUTY_LSB];
      end
    end
  end
endmodule

// File: rtl/pid_trip_latch.sv
module pid_trip_latch
  import pid_pkg::*;
#(
  parameter smp_t TRIP_LVL = 8'hC1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  smp_t vin,
  output logic under_v,
  output logic trip_q
);
  assign under_v = (vin < TRIP_LVL);

  always_ff @(posedge clk) begin
    if (!rst_n)              trip_q <= 1'b0;
    else if (go && under_v)  trip_q <= 1'b1;
  end
endmodule

// File: rtl/pid_trip_ctrl.sv
module pid_trip_ctrl
  import pid_pkg::*;
#(
  parameter int   KP       = 4,
  parameter int   KI       = 1,
  parameter int   KD       = 2,
  parameter int   DUTY_LSB = 3,
  parameter logic [7:0] TRIP_LVL = 8'hC1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [7:0] setpt_i,
  input  logic [7:0] vout_i,
  input  logic [7:0] vin_i,
  output logic [7:0] duty_o,
  output logic       done_o,
  output logic       ovld_o,
  output logic       trip_o
);
  // named internal events, observed by the bound checker
  logic  iter_go;
  logic  under_v;
  logic  commit;
  logic  sum_neg;

  word_t e_now, e_prev, p_term, d_term, i_next;

  assign iter_go = tick_i && !trip_o;
  assign commit  = iter_go && !under_v;

  pid_err_terms #(.KP(KP), .KD(KD)) u_terms (
    .setpt (setpt_i),
    .vout  (vout_i),
    .e_prev(e_prev),
    .e_now (e_now),
    .p_term(p_term),
    .d_term(d_term)
  );

  pid_integ #(.KI(KI)) u_integ (
    .clk   (clk),
    .rst_n (rst_n),
    .commit(commit),
    .e_now (e_now),
    .i_next(i_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      e_prev <= '0;
    else if (commit) e_prev <= e_now;
  end

  pid_out_stage #(.DUTY_LSB(DUTY_LSB)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (iter_go),
    .force_off(under_v),
    .i_term   (i_next),
    .p_term   (p_term),
    .d_term   (d_term),
    .sum_neg  (sum_neg),
    .duty_q   (duty_o),
    .ovld_q   (ovld_o),
    .done_q   (done_o)
  );

  pid_trip_latch #(.TRIP_LVL(TRIP_LVL)) u_trip (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (iter_go),
    .vin    (vin_i),
    .under_v(under_v),
    .trip_q (trip_o)
  );
endmodule

// File: rtl/pid_trip_chk.sv
module pid_trip_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] duty_o,
  input logic       done_o,
  input logic       ovld_o,
  input logic       trip_o,
  input logic       iter_go,
  input logic       under_v,
  input logic       sum_neg
);
  assert_done_after_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iter_go |=> done_o);

  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(iter_go));

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(duty_o) && $stable(ovld_o)));

  assert_ovld_zero_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovld_o |-> (duty_o == 8'h00));

  assert_ovld_from_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ovld_o == $past(sum_neg)));

  assert_trip_duty_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |-> (duty_o == 8'h00));

  assert_trip_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_o) |-> $past(iter_go && under_v));

  assert_trip_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |=> trip_o);

  assert_no_done_tripped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_o && !$rose(trip_o)) |-> !done_o);
endmodule

bind pid_trip_ctrl pid_trip_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .duty_o (duty_o),
  .done_o (done_o),
  .ovld_o (ovld_o),
  .trip_o (trip_o),
  .iter_go(iter_go),
  .under_v(under_v),
  .sum_neg(sum_neg)
);

// File: tb/pid_trip_ctrl_bench.sv
module pid_trip_ctrl_bench;
  localparam int KP = 4;
  localparam int KI = 1;
  localparam int KD = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] setpt_i = '0, vout_i = '0, vin_i = 8'hFF;
  logic [7:0] duty_o;
  logic       done_o, ovld_o, trip_o;

  int errors = 0;
  int checks = 0;

  // reference state
  int m_int = 0, m_e1 = 0, m_duty = 0, m_ovld = 0, m_trip = 0;

  always #10 clk = ~clk;

  pid_trip_ctrl #(.KP(KP), .KI(KI), .KD(KD)) u_pid_trip_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .setpt_i(setpt_i),
    .vout_i(vout_i), .vin_i(vin_i), .duty_o(duty_o), .done_o(done_o),
    .ovld_o(ovld_o), .trip_o(trip_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_int = 0; m_e1 = 0; m_duty = 0; m_ovld = 0; m_trip = 0;
  endtask

  // one tick; returns after checking the result edge and one idle edge
  task automatic do_tick(input int sp, input int vo, input int vi);
    int e0, pro, dif, inew, sum, neg, exp_done;
    exp_done = 0;
    if (m_trip == 0) begin
      exp_done = 1;
      e0 = (sp - vo) & 8'hFF;
      if (e0 >= 128) e0 = e0 | 16'hFF00;                 // R2
      pro  = (KP * e0) & 16'hFFFF;                        // R3
      dif  = (KD * ((m_e1 - e0) & 16'hFFFF)) & 16'hFFFF;  // R4
      inew = (m_int + KI * e0) & 16'hFFFF;                // R5
      sum  = (inew + pro + dif) & 16'hFFFF;               // R6
      neg  = (sum >= 16'h8000) ? 1 : 0;
      m_ovld = neg;
      if (vi < 8'hC1) begin                               // R9 R11
        m_trip = 1;
        m_duty = 0;
      end else begin
        m_duty = neg ? 0 : ((sum >> 3) & 8'hFF);          // R7
        m_int = inew;
        m_e1 = e0;
      end
    end
    @(negedge clk);
    setpt_i = sp[7:0]; vout_i = vo[7:0]; vin_i = vi[7:0]; tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    chk("R8 done pulse", int'(done_o), exp_done);
    chk("R2 R3 R4 R5 R7 duty", int'(duty_o), m_duty);
    chk("R6 ovld", int'(ovld_o), m_ovld);
    chk("R9 R10 trip", int'(trip_o), m_trip);
    @(negedge clk);
    chk("R8 done single", int'(done_o), 0);
    chk("R8 duty held", int'(duty_o), m_duty);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    chk("R1 duty", int'(duty_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 ovld", int'(ovld_o), 0);
    chk("R1 trip", int'(trip_o), 0);
  endtask

  initial begin
    apply_reset();
    // R1: first iteration sees zero integral and zero previous error
    do_tick(8'h05, 8'h02, 8'hFF);
    chk("R1 first iteration duty", int'(duty_o), 1);

    // near-exhaustive sweep of the error space
    for (int s = 0; s < 256; s += 17) begin
      for (int v = 0; v < 256; v++) do_tick(s, v, 8'hFF);
    end

    // R9 boundary: exactly at threshold does not trip
    apply_reset();
    do_tick(8'h40, 8'h10, 8'hC1);
    chk("R9 no trip at threshold", int'(trip_o), 0);

    // R11: drive integral negative, then overload and trip in one tick
    for (int k = 0; k < 8; k++) do_tick(8'h00, 8'h60, 8'hFF);
    chk("R6 overload before trip", int'(ovld_o), 1);
    do_tick(8'h00, 8'h60, 8'hC0);
    chk("R11 ovld with trip", int'(ovld_o), 1);
    chk("R11 trip set", int'(trip_o), 1);

    // R10: ticks refused after trip
    do_tick(8'hFF, 8'h00, 8'hFF);
    do_tick(8'h7F, 8'h00, 8'h00);
    chk("R10 duty off", int'(duty_o), 0);

    // R9: trip from a positive iteration forces duty off
    apply_reset();
    do_tick(8'h60, 8'h00, 8'hFF);
    do_tick(8'h60, 8'h00, 8'h10);
    chk("R9 duty forced off", int'(duty_o), 0);

    // R1: reset clears state; fresh iteration matches a fresh model
    apply_reset();
    do_tick(8'h30, 8'h20, 8'hFF);
    do_tick(8'h20, 8'h30, 8'hFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule